// File: doc/BRIEF.md
# Procedure Frame Link Sequencer

This block carries out procedure entry and exit for a word-addressed stack machine. It owns the top-of-stack pointer S, the frame pointer Q, the index register X, the program counter P, the code base PB, an 8-bit status byte and an 8-bit code segment number. It also owns a small stack RAM that holds the frame records.

On a call it writes a four-word linkage record above the top of stack, one word per cycle. The record holds:
- X;
- the return address relative to PB;
- the status byte packed with the segment number;
- a relative back-link to the caller's frame.

Q then points at the newest back-link, so the frames form a chain. On an exit, S first jumps to Q and Q follows the back-link. S then steps down through the record, restoring status and segment, then P (rebased on the current PB), then X. Last, S drops by a caller-supplied count to throw away the callee's parameters.

Commands use a simple level-sampled handshake. A command is taken only while the unit is idle. Each call or exit keeps `busy` high for five cycles and ends with a one-cycle `done` pulse. A call that would run past the RAM is refused with `ovf_err`. An exit while Q still holds its reset value is refused with `unf_err`. A load command writes the caller-state registers from the surrounding datapath.

Top module: `frame_link_top`

## Requirements
- R1: After reset, S and Q both equal BASE (default 4); X, P, PB, status and segment are 0; busy, done, ovf_err and unf_err are 0.
- R2: A command is accepted only in a cycle where busy is low, with priority call, then exit, then load. An accepted call or exit holds busy high for exactly 5 cycles, followed by done high for exactly one cycle. Requests seen while busy have no effect.
- R3: An accepted load writes X, P, PB, status and segment from the load inputs at the accepting edge, without raising busy.
- R4: A call writes, at S+1, S+2, S+3 and S+4 in that order, these four words: X; (P+1−PB) mod 2^16; {status, segment} with status in bits 15:8; and (S+4−Q) mod 2^16. S rises by one per written word, ending at S+4.
- R5: When a call completes, Q equals the new S and P equals the call target.
- R6: A call with S+4 ≥ DEPTH (default 64) raises ovf_err for one cycle and changes no register, and busy stays low.
- R7: In an exit, S is first set to Q; Q then becomes (Q − stored back-link) mod 2^16.
- R8: Stepping S down from the back-link word, the exit restores status (bits 15:8) and segment (bits 7:0), then P = (PB + saved relative address) mod 2^16 using the PB current at exit time, then X.
- R9: An exit leaves S = Qold − 4 − discard count, saturating at 0 when the count exceeds Qold − 4.
- R10: An exit while Q equals BASE raises unf_err for one cycle and changes no register, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Request a procedure call |
| call_target | input | 16 | Entry address loaded into P at call completion |
| exit_req | input | 1 | Request a procedure exit |
| exit_discard | input | 16 | Number of parameter words to drop at exit |
| load_req | input | 1 | Request a write of caller-state registers |
| load_x | input | 16 | Value for X |
| load_p | input | 16 | Value for P |
| load_pb | input | 16 | Value for PB |
| load_sta | input | 8 | Value for the status byte |
| load_seg | input | 8 | Value for the segment number |
| s_ptr | output | 16 | Top-of-stack pointer S |
| q_ptr | output | 16 | Frame pointer Q |
| x_reg | output | 16 | Index register X |
| p_reg | output | 16 | Program counter P |
| pb_reg | output | 16 | Code base PB |
| sta_reg | output | 8 | Status byte |
| seg_reg | output | 8 | Code segment number |
| busy | output | 1 | Call or exit in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf_err | output | 1 | One-cycle pulse: call refused, stack full |
| unf_err | output | 1 | One-cycle pulse: exit refused, no frame |

## Verification
The assertions assume that every exit walks a record that an earlier call built, so Q always addresses a valid back-link in RAM. The refusal checks assume S never wraps past 2^16 between commands. The stimulus keeps within these assumptions by only entering frames through calls and by letting the overflow refusal cap the stack height. The discard counts in the stimulus are either small or deliberately oversized, so that only the saturation rule decides the final S.

// File: rtl/frame_link_pkg.sv
package frame_link_pkg;
  localparam int unsigned FL_DW   = 16;
  localparam int unsigned FL_HALF = FL_DW / 2;

  typedef logic [FL_DW-1:0]   word_t;
  typedef logic [FL_HALF-1:0] half_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_M1, PH_M2, PH_M3, PH_M4
  } phase_t;

  typedef enum logic {OP_CALL, OP_EXIT} op_t;

  // return address kept relative to the code base
  function automatic word_t ret_rel(input word_t p, input word_t pb);
    return word_t'(p + word_t'(1) - pb);
  endfunction

  // back-link from the new record to the caller frame
  function automatic word_t link_delta(input word_t mark, input word_t q_old);
    return word_t'(mark - q_old);
  endfunction

  function automatic word_t link_back(input word_t q, input word_t delta);
    return word_t'(q - delta);
  endfunction

  function automatic word_t rebase(input word_t pb, input word_t rel);
    return word_t'(pb + rel);
  endfunction

  function automatic word_t pack_status(input half_t sta, input half_t seg);
    return {sta, seg};
  endfunction

  // S after the last record word, lowered by the discard count, floor at zero
  function automatic word_t discard_to(input word_t s, input word_t cnt);
    word_t floor_s;
    floor_s = word_t'(s - word_t'(1));
    return (cnt > floor_s) ? '0 : word_t'(floor_s - cnt);
  endfunction
endpackage

// File: rtl/frame_link_ram.sv
module frame_link_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/frame_link_seq.sv
module frame_link_seq
  import frame_link_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   call_req,
  input  logic   exit_req,
  input  logic   load_req,
  input  logic   call_blocked,
  input  logic   exit_blocked,
  output phase_t phase,
  output op_t    op,
  output logic   call_go,
  output logic   exit_go,
  output logic   load_go,
  output logic   done,
  output logic   ovf_err,
  output logic   unf_err
);
  logic   idle;
  logic   ovf_hit, unf_hit;
  phase_t phase_nx;

  always_comb begin
    idle    = (phase == PH_IDLE);
    call_go = idle && call_req && !call_blocked;
    ovf_hit = idle && call_req && call_blocked;
    exit_go = idle && !call_req && exit_req && !exit_blocked;
    unf_hit = idle && !call_req && exit_req && exit_blocked;
    load_go = idle && !call_req && !exit_req && load_req;
  end

  always_comb begin
    unique case (phase)
      PH_IDLE:  phase_nx = (call_go || exit_go) ? PH_SETUP : PH_IDLE;
      PH_SETUP: phase_nx = PH_M1;
      PH_M1:    phase_nx = PH_M2;
      PH_M2:    phase_nx = PH_M3;
      PH_M3:    phase_nx = PH_M4;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      op      <= OP_CALL;
      done    <= 1'b0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      phase   <= phase_nx;
      done    <= (phase == PH_M4);
      ovf_err <= ovf_hit;
      unf_err <= unf_hit;
      if (call_go)      op <= OP_CALL;
      else if (exit_go) op <= OP_EXIT;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase) == PH_M4); // R2
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err || unf_err) |-> phase == PH_IDLE); // R6
endmodule

// File: rtl/frame_link_top.sv
module frame_link_top
  import frame_link_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned BASE  = 4,
  localparam int unsigned DW   = FL_DW,
  localparam int unsigned HW   = FL_HALF,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned RECW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic [DW-1:0] call_target,
  input  logic          exit_req,
  input  logic [DW-1:0] exit_discard,
  input  logic          load_req,
  input  logic [DW-1:0] load_x,
  input  logic [DW-1:0] load_p,
  input  logic [DW-1:0] load_pb,
  input  logic [HW-1:0] load_sta,
  input  logic [HW-1:0] load_seg,
  output logic [DW-1:0] s_ptr,
  output logic [DW-1:0] q_ptr,
  output logic [DW-1:0] x_reg,
  output logic [DW-1:0] p_reg,
  output logic [DW-1:0] pb_reg,
  output logic [HW-1:0] sta_reg,
  output logic [HW-1:0] seg_reg,
  output logic          busy,
  output logic          done,
  output logic          ovf_err,
  output logic          unf_err
);
  phase_t phase;
  op_t    op;
  logic   call_go, exit_go, load_go;
  logic   call_blocked, exit_blocked;

  word_t s_q, q_q, x_q, p_q, pb_q;
  half_t sta_q, seg_q;
  word_t tgt_q, cnt_q;

  // named internal events
  logic  in_record;
  logic  call_write, call_fin;
  logic  exit_link, exit_stat, exit_ret, exit_idx;
  word_t s_up;
  word_t wr_word;
  word_t rd_word;

  assign in_record    = (phase == PH_M1) || (phase == PH_M2) ||
                        (phase == PH_M3) || (phase == PH_M4);
  assign call_write   = in_record && (op == OP_CALL);
  assign call_fin     = call_write && (phase == PH_M4);
  assign exit_link    = (op == OP_EXIT) && (phase == PH_M1);
  assign exit_stat    = (op == OP_EXIT) && (phase == PH_M2);
  assign exit_ret     = (op == OP_EXIT) && (phase == PH_M3);
  assign exit_idx     = (op == OP_EXIT) && (phase == PH_M4);
  assign s_up         = word_t'(s_q + word_t'(1));
  assign call_blocked = (32'(s_q) + RECW) >= DEPTH;
  assign exit_blocked = (q_q == word_t'(BASE));

  always_comb begin
    unique case (phase)
      PH_M1:   wr_word = x_q;
      PH_M2:   wr_word = ret_rel(p_q, pb_q);
      PH_M3:   wr_word = pack_status(sta_q, seg_q);
      default: wr_word = link_delta(s_up, q_q);
    endcase
  end

  frame_link_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_req     (call_req),
    .exit_req     (exit_req),
    .load_req     (load_req),
    .call_blocked (call_blocked),
    .exit_blocked (exit_blocked),
    .phase        (phase),
    .op           (op),
    .call_go      (call_go),
    .exit_go      (exit_go),
    .load_go      (load_go),
    .done         (done),
    .ovf_err      (ovf_err),
    .unf_err      (unf_err)
  );

  frame_link_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk     (clk),
    .wr_en   (call_write),
    .wr_addr (s_up[AW-1:0]),
    .wr_data (wr_word),
    .rd_addr (s_q[AW-1:0]),
    .rd_data (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= word_t'(BASE);
      q_q   <= word_t'(BASE);
      x_q   <= '0;
      p_q   <= '0;
      pb_q  <= '0;
      sta_q <= '0;
      seg_q <= '0;
      tgt_q <= '0;
      cnt_q <= '0;
    end else begin
      if (call_go) tgt_q <= call_target;
      if (exit_go) cnt_q <= exit_discard;
      if (load_go) begin
        x_q   <= load_x;
        p_q   <= load_p;
        pb_q  <= load_pb;
        sta_q <= load_sta;
        seg_q <= load_seg;
      end
      if (phase == PH_SETUP && op == OP_EXIT) s_q <= q_q;
      if (call_write) s_q <= s_up;
      if (call_fin) begin
        q_q <= s_up;
        p_q <= tgt_q;
      end
      if (exit_link) begin
        q_q <= link_back(q_q, rd_word);
        s_q <= word_t'(s_q - word_t'(1));
      end
      if (exit_stat) begin
        sta_q <= rd_word[DW-1:HW];
        seg_q <= rd_word[HW-1:0];
        s_q   <= word_t'(s_q - word_t'(1));
      end
      if (exit_ret) begin
        p_q <= rebase(pb_q, rd_word);
        s_q <= word_t'(s_q - word_t'(1));
      end
      if (exit_idx) begin
        x_q <= rd_word;
        s_q <= discard_to(s_q, cnt_q);
      end
    end
  end

  assign s_ptr   = s_q;
  assign q_ptr   = q_q;
  assign x_reg   = x_q;
  assign p_reg   = p_q;
  assign pb_reg  = pb_q;
  assign sta_reg = sta_q;
  assign seg_reg = seg_q;
  assign busy    = (phase != PH_IDLE);

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    call_write |=> s_ptr == word_t'($past(s_ptr) + word_t'(1))); // R4
  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    call_fin |=> q_ptr == s_ptr); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    call_write |-> 32'(s_up) < DEPTH); // R6
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $stable(s_ptr) && $stable(q_ptr) && !busy); // R6
  AST_EXIT_AT_Q: assert property (@(posedge clk) disable iff (!rst_n)
    exit_link |-> s_ptr == q_ptr); // R7
  AST_EXIT_DESCENT: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_link || exit_stat || exit_ret) |=>
      s_ptr == word_t'($past(s_ptr) - word_t'(1))); // R8
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |-> $stable(s_ptr) && $stable(q_ptr) && $stable(x_reg) && !busy); // R10
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> !busy); // R3
endmodule

// File: tb/frame_link_top_bench.sv
module frame_link_top_bench;
  localparam int DEPTH = 64;
  localparam int BASE  = 4;
  localparam int M16   = 32'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_req = 1'b0, exit_req = 1'b0, load_req = 1'b0;
  logic [15:0] call_target = '0, exit_discard = '0;
  logic [15:0] load_x = '0, load_p = '0, load_pb = '0;
  logic [7:0]  load_sta = '0, load_seg = '0;
  logic [15:0] s_ptr, q_ptr, x_reg, p_reg, pb_reg;
  logic [7:0]  sta_reg, seg_reg;
  logic        busy, done, ovf_err, unf_err;

  always #4 clk = ~clk;

  frame_link_top #(.DEPTH(DEPTH), .BASE(BASE)) u_frame_link_top (
    .clk(clk), .rst_n(rst_n),
    .call_req(call_req), .call_target(call_target),
    .exit_req(exit_req), .exit_discard(exit_discard),
    .load_req(load_req), .load_x(load_x), .load_p(load_p), .load_pb(load_pb),
    .load_sta(load_sta), .load_seg(load_seg),
    .s_ptr(s_ptr), .q_ptr(q_ptr), .x_reg(x_reg), .p_reg(p_reg), .pb_reg(pb_reg),
    .sta_reg(sta_reg), .seg_reg(seg_reg),
    .busy(busy), .done(done), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s, m_q, m_x, m_p, m_pb, m_sta, m_seg, m_tgt, m_cnt, m_step;
  bit m_busy, m_done, m_ovf, m_unf, m_is_exit;
  int m_mem [int];
  int m_words [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = BASE; m_q = BASE; m_x = 0; m_p = 0; m_pb = 0; m_sta = 0; m_seg = 0;
      m_busy = 0; m_done = 0; m_ovf = 0; m_unf = 0; m_step = 0;
      m_words.delete();
    end else begin
      m_done = 0; m_ovf = 0; m_unf = 0;
      if (m_busy) begin
        if (m_step == 0) begin
          if (m_is_exit) m_s = m_q;
        end else if (!m_is_exit) begin
          m_s = m_s + 1;
          m_mem[m_s] = m_words.pop_front();
          if (m_step == 4) begin m_q = m_s; m_p = m_tgt; end
        end else begin
          case (m_step)
            1: m_q = (m_q - m_mem[m_s]) & M16;
            2: begin m_sta = m_mem[m_s] >> 8; m_seg = m_mem[m_s] & 8'hFF; end
            3: m_p = (m_pb + m_mem[m_s]) & M16;
            default: m_x = m_mem[m_s];
          endcase
          if (m_step < 4) m_s = m_s - 1;
          else m_s = (m_cnt > m_s - 1) ? 0 : m_s - 1 - m_cnt;
        end
        if (m_step == 4) begin m_busy = 0; m_done = 1; end
        else m_step++;
      end else if (call_req) begin
        if (m_s + 4 >= DEPTH) m_ovf = 1;
        else begin
          m_busy = 1; m_step = 0; m_is_exit = 0; m_tgt = call_target;
          m_words.push_back(m_x);
          m_words.push_back((m_p + 1 - m_pb) & M16);
          m_words.push_back((m_sta << 8) | m_seg);
          m_words.push_back((m_s + 4 - m_q) & M16);
        end
      end else if (exit_req) begin
        if (m_q == BASE) m_unf = 1;
        else begin m_busy = 1; m_step = 0; m_is_exit = 1; m_cnt = exit_discard; end
      end else if (load_req) begin
        m_x = load_x; m_p = load_p; m_pb = load_pb; m_sta = load_sta; m_seg = load_seg;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ok;
      ok = (int'(s_ptr) == m_s) && (int'(q_ptr) == m_q) && (int'(x_reg) == m_x) &&
           (int'(p_reg) == m_p) && (int'(pb_reg) == m_pb) &&
           (int'(sta_reg) == m_sta) && (int'(seg_reg) == m_seg) &&
           (busy == m_busy) && (done == m_done) &&
           (ovf_err == m_ovf) && (unf_err == m_unf);
      n_checks++;
      if (!ok) begin
        n_fail++;
        $display("FAIL R2 cycle model: S=%0h/%0h Q=%0h/%0h X=%0h/%0h P=%0h/%0h busy=%0b/%0b done=%0b/%0b",
                 s_ptr, m_s, q_ptr, m_q, x_reg, m_x, p_reg, m_p, busy, m_busy, done, m_done);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  int  busy_cnt;
  bit  seen_done, seen_ovf, seen_unf;

  task automatic issue(input bit is_exit, input int arg);
    @(negedge clk);
    if (is_exit) begin exit_req = 1; exit_discard = 16'(arg); end
    else begin call_req = 1; call_target = 16'(arg); end
    @(negedge clk);
    call_req = 0; exit_req = 0;
    seen_ovf = ovf_err; seen_unf = unf_err; busy_cnt = 0;
    while (busy) begin busy_cnt++; @(negedge clk); end
    seen_done = done;
  endtask

  task automatic load(input int x, input int p, input int pb, input int sta, input int seg);
    @(negedge clk);
    load_req = 1; load_x = 16'(x); load_p = 16'(p); load_pb = 16'(pb);
    load_sta = 8'(sta); load_seg = 8'(seg);
    @(negedge clk);
    load_req = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int x_before;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(s_ptr == BASE && q_ptr == BASE, "R1 S/Q reset", s_ptr, BASE);
    check(x_reg == 0 && p_reg == 0 && pb_reg == 0 && sta_reg == 0 && seg_reg == 0,
          "R1 regs reset", x_reg, 0);
    check(!busy && !done && !ovf_err && !unf_err, "R1 flags reset", busy, 0);

    // R10 exit with no frame
    issue(1, 0);
    check(seen_unf, "R10 unf_err", seen_unf, 1);
    check(s_ptr == BASE && q_ptr == BASE && busy_cnt == 0, "R10 no change", s_ptr, BASE);

    // R3 load
    load(16'h1234, 16'h0100, 16'h0040, 8'hA5, 8'h3C);
    check(x_reg == 16'h1234 && p_reg == 16'h0100 && pb_reg == 16'h0040, "R3 load X/P/PB", x_reg, 16'h1234);
    check(sta_reg == 8'hA5 && seg_reg == 8'h3C && !busy, "R3 load status", sta_reg, 8'hA5);

    // first call: R2 timing, R4 S, R5 link
    issue(0, 16'h0200);
    check(busy_cnt == 5, "R2 busy length", busy_cnt, 5);
    check(seen_done, "R2 done pulse", seen_done, 1);
    @(negedge clk);
    check(!done, "R2 done single", done, 0);
    check(s_ptr == 8, "R4 S after call", s_ptr, 8);
    check(q_ptr == 8 && p_reg == 16'h0200, "R5 Q/P after call", q_ptr, 8);

    // second call with new caller state
    load(16'h5555, 16'h0280, 16'h0040, 8'h5A, 8'hC3);
    issue(0, 16'h0400);
    check(s_ptr == 12 && q_ptr == 12, "R5 Q follows S", q_ptr, 12);

    // scramble then exit, discard 0
    load(16'h7777, 16'h0500, 16'h0040, 8'h00, 8'h00);
    issue(1, 0);
    check(busy_cnt == 5 && seen_done, "R2 exit timing", busy_cnt, 5);
    check(q_ptr == 8, "R7 Q back-link", q_ptr, 8);
    check(x_reg == 16'h5555, "R8 X restore", x_reg, 16'h5555);
    check(p_reg == 16'h0281, "R8 P restore", p_reg, 16'h0281);
    check(sta_reg == 8'h5A && seg_reg == 8'hC3, "R8 status restore", sta_reg, 8'h5A);
    check(s_ptr == 8, "R9 S discard 0", s_ptr, 8);

    // new PB before exit: P is rebased, discard 2
    load(16'h0000, 16'h0000, 16'h1000, 8'h00, 8'h00);
    issue(1, 2);
    check(q_ptr == BASE, "R7 Q to first frame", q_ptr, BASE);
    check(p_reg == 16'h10C1, "R8 P rebased on PB", p_reg, 16'h10C1);
    check(x_reg == 16'h1234 && sta_reg == 8'hA5 && seg_reg == 8'h3C, "R8 first caller state", x_reg, 16'h1234);
    check(s_ptr == 2, "R9 S discard 2", s_ptr, 2);

    issue(1, 0);
    check(seen_unf && s_ptr == 2, "R10 unf after unwinding", s_ptr, 2);

    // priority: call beats exit
    @(negedge clk);
    call_req = 1; exit_req = 1; call_target = 16'h0600;
    @(negedge clk);
    call_req = 0; exit_req = 0;
    while (busy) @(negedge clk);
    check(s_ptr == 6 && q_ptr == 6, "R2 call priority", s_ptr, 6);

    // requests while busy are ignored
    x_before = x_reg;
    @(negedge clk);
    call_req = 1; call_target = 16'h0700;
    @(negedge clk);
    call_req = 0; exit_req = 1; exit_discard = 0;
    load_req = 1; load_x = 16'hDEAD;
    while (busy) @(negedge clk);
    exit_req = 0; load_req = 0;
    @(negedge clk);
    check(int'(x_reg) == x_before, "R2 load ignored while busy", x_reg, x_before);
    check(q_ptr == 10 && s_ptr == 10, "R2 exit ignored while busy", q_ptr, 10);

    // R6 overflow
    while (int'(s_ptr) + 4 < DEPTH) issue(0, 16'h0800);
    check(s_ptr == 62, "R6 stack height", s_ptr, 62);
    issue(0, 16'h0900);
    check(seen_ovf && busy_cnt == 0, "R6 ovf_err", seen_ovf, 1);
    check(s_ptr == 62 && q_ptr == 62 && p_reg == 16'h0800, "R6 no change", s_ptr, 62);

    // R9 saturation
    issue(1, 16'hFFFF);
    check(s_ptr == 0, "R9 discard saturates", s_ptr, 0);
    check(q_ptr == 58, "R7 Q after deep exit", q_ptr, 58);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule